// File: doc/BRIEF.md
# Display RAM Command and Address Sequencer

This block sits between a byte-wide host write bus and the write port of an external display memory. Each host byte comes with a register-select bit. When that bit is low the byte is an opcode. When it is high the byte is a parameter or a pixel byte. Three opcodes are recognised:

- load the row (page) address from the next parameter byte,
- load the column address from the next parameter byte,
- start a data stream in which every later parameter byte is written to memory.

The block holds a page counter and a column counter. For each data byte it drives a one-cycle write strobe together with the current page, the current column and the byte. It then steps one of the two counters, so a host can fill a region without readdressing. A level input picks which counter steps.

Parameters set the byte and address widths, the largest legal page and column, the three opcode values, and whether an out-of-range address is clamped to the limit or dropped.

Top module: `dram_cmd_seq`

## Requirements
- R1: A synchronous active-high `rst` clears both counters to 0, drops `ram_we`, and returns the decoder to waiting for an opcode. After reset, data bytes are not written until a data-start opcode arrives.
- R2: A byte is taken only on a rising clock edge with `wr_en` high. `rs`=0 marks an opcode and `rs`=1 marks a parameter or data byte. A data byte that arrives while no data stream is open causes no write.
- R3: Opcode 0xB1 followed by a byte with `rs`=1 loads the page counter from bits 5..0 of that byte. Bits 7..6 are ignored.
- R4: In the default clamping variant, a page parameter above 32 loads 32. The page counter never leaves 0..32.
- R5: Opcode 0x13 followed by a byte with `rs`=1 loads all 8 bits into the column counter. A value above 159 loads 159. The column counter never leaves 0..159.
- R6: After opcode 0x1D, every byte with `rs`=1 gives `ram_we`=1 for exactly one cycle, in the cycle after the byte is taken. During that cycle `ram_page` and `ram_col` show the address before the step, and `ram_data` shows the byte.
- R7: With `dir_page`=0 each data write steps the column by one, from 159 to 0. The page is left unchanged.
- R8: With `dir_page`=1 each data write steps the page by one, from 32 to 0. The column is left unchanged.
- R9: Any opcode ends an open data stream or a pending parameter wait. An opcode other than 0xB1, 0x13 or 0x1D leaves the decoder idle, so the data bytes that follow are not written.
- R10: While `wr_en` is low, `din` and `rs` have no effect: no write occurs and no counter moves.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host byte strobe, one byte per cycle while high |
| rs | input | 1 | Register select: 0 opcode, 1 parameter/data |
| din | input | 8 | Host byte |
| dir_page | input | 1 | Step select: 0 column steps, 1 page steps |
| ram_we | output | 1 | Display memory write strobe |
| ram_page | output | 6 | Page address of the write |
| ram_col | output | 8 | Column address of the write |
| ram_data | output | 8 | Byte to write |

## Verification
The properties assume the following about the inputs:
- `rs` and `din` are meaningful only in cycles with `wr_en` high.
- A counter is never told to load and to step in the same cycle. The decoder makes that impossible, because a parameter byte and a data byte can never arrive in the same cycle.
- `dir_page` is steady during the cycle in which a data byte is taken.

The bench drives every input at the falling edge, one byte per strobe. It holds `dir_page` fixed within each byte, and it leaves `rs` and `din` moving while `wr_en` is low to show that they are ignored then. The stimulus pushes both counters through their wrap points and feeds parameters past both limits.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE      = 2'd0,
      SEQ_WAIT_PAGE = 2'd1,
      SEQ_WAIT_COL  = 2'd2,
      SEQ_STREAM    = 2'd3
   } seq_state_t;
endpackage

// File: rtl/dram_cmd_decode.sv
module dram_cmd_decode
   import dram_seq_pkg::*;
#(
   parameter int               DATA_W   = 8,
   parameter logic [DATA_W-1:0] OP_PAGE  = 8'hB1,
   parameter logic [DATA_W-1:0] OP_COL   = 8'h13,
   parameter logic [DATA_W-1:0] OP_WRITE = 8'h1D
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic              rs,
   input  logic [DATA_W-1:0] din,
   output logic              page_load,
   output logic              col_load,
   output logic              data_take,
   output seq_state_t        state
);
   if (OP_PAGE == OP_COL || OP_PAGE == OP_WRITE || OP_COL == OP_WRITE) begin : g_bad_op
      $error("dram_cmd_decode: opcodes must be distinct");
   end

   logic       is_cmd, is_par;
   seq_state_t state_nx;

   assign is_cmd    = wr_en && !rs;
   assign is_par    = wr_en &&  rs;
   assign page_load = is_par && (state == SEQ_WAIT_PAGE);
   assign col_load  = is_par && (state == SEQ_WAIT_COL);
   assign data_take = is_par && (state == SEQ_STREAM);

   always_comb begin
      state_nx = state;
      if (is_cmd) begin
         if (din == OP_PAGE)       state_nx = SEQ_WAIT_PAGE;
         else if (din == OP_COL)   state_nx = SEQ_WAIT_COL;
         else if (din == OP_WRITE) state_nx = SEQ_STREAM;
         else                      state_nx = SEQ_IDLE;
      end else if (page_load || col_load) begin
         state_nx = SEQ_IDLE;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) state <= SEQ_IDLE;
      else     state <= state_nx;
   end

   // R9: an unknown opcode always leaves the decoder idle
   assert_unknown_idle_R9: assert property (@(posedge clk) disable iff (rst)
      (is_cmd && din != OP_PAGE && din != OP_COL && din != OP_WRITE) |=> state == SEQ_IDLE);
   // R3 / R5: a parameter byte always closes the wait
   assert_param_closes_R3: assert property (@(posedge clk) disable iff (rst)
      (page_load || col_load) |=> state == SEQ_IDLE);
   // R10: with no strobe the state holds
   assert_no_strobe_hold_R10: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> $stable(state));
endmodule

// File: rtl/dram_addr_counter.sv
module dram_addr_counter #(
   parameter int W     = 8,
   parameter int MAX   = 159,
   parameter bit CLAMP = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         incr,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] MAX_V = W'(MAX);

   if (MAX < 1 || MAX >= (1 << W)) begin : g_bad_max
      $error("dram_addr_counter: MAX does not fit W bits");
   end

   logic [W-1:0] load_fix;
   logic         load_ok;

   if (CLAMP) begin : g_clamp
      assign load_fix = (load_val > MAX_V) ? MAX_V : load_val;
      assign load_ok  = 1'b1;
   end else begin : g_drop
      assign load_fix = load_val;
      assign load_ok  = (load_val <= MAX_V);
   end

   always_ff @(posedge clk) begin
      if (rst)                  cnt <= '0;
      else if (load && load_ok) cnt <= load_fix;
      else if (incr)            cnt <= (cnt == MAX_V) ? '0 : cnt + 1'b1;
   end

   // R4 / R5: the counter stays inside its legal range
   assert_cnt_range_R4: assert property (@(posedge clk) disable iff (rst)
      cnt <= MAX_V);
   // R7 / R8: a step at the limit wraps to zero
   assert_wrap_R7: assert property (@(posedge clk) disable iff (rst)
      (incr && !load && cnt == MAX_V) |=> cnt == '0);
   // R7 / R8: a step below the limit adds one
   assert_step_R8: assert property (@(posedge clk) disable iff (rst)
      (incr && !load && cnt != MAX_V) |=> cnt == $past(cnt) + 1'b1);
   // R10: no load and no step means no change
   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
      (!incr && !load) |=> $stable(cnt));
endmodule

// File: rtl/dram_cmd_seq.sv
module dram_cmd_seq
   import dram_seq_pkg::*;
#(
   parameter int                DATA_W   = 8,
   parameter int                PAGE_W   = 6,
   parameter int                COL_W    = 8,
   parameter int                PAGE_MAX = 32,
   parameter int                COL_MAX  = 159,
   parameter logic [DATA_W-1:0] OP_PAGE  = 8'hB1,
   parameter logic [DATA_W-1:0] OP_COL   = 8'h13,
   parameter logic [DATA_W-1:0] OP_WRITE = 8'h1D,
   parameter bit                CLAMP    = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic              rs,
   input  logic [7:0]        din,
   input  logic              dir_page,
   output logic              ram_we,
   output logic [5:0]        ram_page,
   output logic [7:0]        ram_col,
   output logic [7:0]        ram_data
);
   if (DATA_W != 8 || PAGE_W != 6 || COL_W != 8) begin : g_bad_port
      $error("dram_cmd_seq: port widths are fixed at 8/6/8");
   end
   if (PAGE_W > DATA_W || COL_W > DATA_W) begin : g_bad_w
      $error("dram_cmd_seq: address wider than host byte");
   end

   logic              page_load, col_load, data_take;
   logic              step_page, step_col;
   logic [PAGE_W-1:0] page_cnt;
   logic [COL_W-1:0]  col_cnt;
   seq_state_t        state;

   dram_cmd_decode #(
      .DATA_W(DATA_W), .OP_PAGE(OP_PAGE), .OP_COL(OP_COL), .OP_WRITE(OP_WRITE)
   ) u_dec (
      .clk(clk), .rst(rst), .wr_en(wr_en), .rs(rs), .din(din),
      .page_load(page_load), .col_load(col_load), .data_take(data_take),
      .state(state)
   );

   assign step_page = data_take &&  dir_page;
   assign step_col  = data_take && !dir_page;

   dram_addr_counter #(.W(PAGE_W), .MAX(PAGE_MAX), .CLAMP(CLAMP)) u_page (
      .clk(clk), .rst(rst), .load(page_load), .load_val(din[PAGE_W-1:0]),
      .incr(step_page), .cnt(page_cnt)
   );

   dram_addr_counter #(.W(COL_W), .MAX(COL_MAX), .CLAMP(CLAMP)) u_col (
      .clk(clk), .rst(rst), .load(col_load), .load_val(din[COL_W-1:0]),
      .incr(step_col), .cnt(col_cnt)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         ram_we   <= 1'b0;
         ram_page <= '0;
         ram_col  <= '0;
         ram_data <= '0;
      end else begin
         ram_we <= data_take;
         if (data_take) begin
            ram_page <= page_cnt;
            ram_col  <= col_cnt;
            ram_data <= din;
         end
      end
   end

   // R1: the strobe is low in the first cycle after reset
   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !ram_we);
   // R6: every strobe comes from a data byte taken one edge earlier
   assert_we_source_R6: assert property (@(posedge clk) disable iff (rst)
      ram_we |-> $past(wr_en && rs));
   // R2: writes only happen while a data stream was open
   assert_stream_only_R2: assert property (@(posedge clk) disable iff (rst)
      ram_we |-> $past(state == SEQ_STREAM));
   // R6: the written byte is the one that was presented
   assert_data_match_R6: assert property (@(posedge clk) disable iff (rst)
      ram_we |-> ram_data == $past(din));
   // R7: a column step leaves the page alone
   assert_col_step_page_R7: assert property (@(posedge clk) disable iff (rst)
      step_col |=> $stable(page_cnt));
   // R8: a page step leaves the column alone
   assert_page_step_col_R8: assert property (@(posedge clk) disable iff (rst)
      step_page |=> $stable(col_cnt));
endmodule

// File: tb/dram_cmd_seq_tb.sv
module dram_cmd_seq_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 27;

   // vector: rs, din, dir, exp_we, exp_page, exp_col, exp_data
   localparam logic [32:0] VEC [0:NVEC-1] = '{
      {1'b0, 8'h13, 1'b0, 1'b0, 6'd0,  8'd0,   8'h00}, // 0  R5 column opcode
      {1'b1, 8'h9E, 1'b0, 1'b0, 6'd0,  8'd0,   8'h00}, // 1  R5 column=158
      {1'b0, 8'h1D, 1'b0, 1'b0, 6'd0,  8'd0,   8'h00}, // 2  R6 open stream
      {1'b1, 8'hAA, 1'b0, 1'b1, 6'd0,  8'd158, 8'hAA}, // 3  R6 R7
      {1'b1, 8'hBB, 1'b0, 1'b1, 6'd0,  8'd159, 8'hBB}, // 4  R7
      {1'b1, 8'hCC, 1'b0, 1'b1, 6'd0,  8'd0,   8'hCC}, // 5  R7 wrap 159->0
      {1'b0, 8'hB1, 1'b0, 1'b0, 6'd0,  8'd0,   8'h00}, // 6  R3 page opcode
      {1'b1, 8'hDF, 1'b0, 1'b0, 6'd0,  8'd0,   8'h00}, // 7  R3 bits 7..6 ignored -> 31
      {1'b0, 8'h1D, 1'b0, 1'b0, 6'd0,  8'd0,   8'h00}, // 8
      {1'b1, 8'h11, 1'b1, 1'b1, 6'd31, 8'd1,   8'h11}, // 9  R3 R8
      {1'b1, 8'h22, 1'b1, 1'b1, 6'd32, 8'd1,   8'h22}, // 10 R8
      {1'b1, 8'h33, 1'b1, 1'b1, 6'd0,  8'd1,   8'h33}, // 11 R8 wrap 32->0
      {1'b0, 8'h13, 1'b0, 1'b0, 6'd0,  8'd0,   8'h00}, // 12
      {1'b1, 8'hFF, 1'b0, 1'b0, 6'd0,  8'd0,   8'h00}, // 13 R5 clamp to 159
      {1'b0, 8'h1D, 1'b0, 1'b0, 6'd0,  8'd0,   8'h00}, // 14
      {1'b1, 8'h44, 1'b0, 1'b1, 6'd1,  8'd159, 8'h44}, // 15 R5
      {1'b0, 8'hB1, 1'b0, 1'b0, 6'd0,  8'd0,   8'h00}, // 16
      {1'b1, 8'h3F, 1'b0, 1'b0, 6'd0,  8'd0,   8'h00}, // 17 R4 clamp to 32
      {1'b0, 8'h1D, 1'b0, 1'b0, 6'd0,  8'd0,   8'h00}, // 18
      {1'b1, 8'h55, 1'b1, 1'b1, 6'd32, 8'd0,   8'h55}, // 19 R4
      {1'b0, 8'h77, 1'b0, 1'b0, 6'd0,  8'd0,   8'h00}, // 20 R9 unknown opcode
      {1'b1, 8'h66, 1'b0, 1'b0, 6'd0,  8'd0,   8'h00}, // 21 R9 R2 no write
      {1'b0, 8'h1D, 1'b0, 1'b0, 6'd0,  8'd0,   8'h00}, // 22
      {1'b1, 8'h77, 1'b0, 1'b1, 6'd0,  8'd0,   8'h77}, // 23 R6
      {1'b0, 8'hB1, 1'b0, 1'b0, 6'd0,  8'd0,   8'h00}, // 24 R9 page wait
      {1'b0, 8'h1D, 1'b0, 1'b0, 6'd0,  8'd0,   8'h00}, // 25 R9 opcode ends wait
      {1'b1, 8'h88, 1'b0, 1'b1, 6'd0,  8'd1,   8'h88}  // 26 R9 page kept
   };

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       wr_en = 1'b0;
   logic       rs = 1'b0;
   logic [7:0] din = '0;
   logic       dir_page = 1'b0;
   logic       ram_we;
   logic [5:0] ram_page;
   logic [7:0] ram_col;
   logic [7:0] ram_data;
   int         checks = 0;
   int         failures = 0;
   bit         done = 1'b0;

   dram_cmd_seq u_dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .rs(rs), .din(din), .dir_page(dir_page),
      .ram_we(ram_we), .ram_page(ram_page), .ram_col(ram_col), .ram_data(ram_data)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic send(input logic r, input logic [7:0] d, input logic dr);
      @(negedge clk);
      rs = r; din = d; dir_page = dr; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic expect_write(input string req, input logic [5:0] p,
                               input logic [7:0] c, input logic [7:0] d);
      chk(ram_we == 1'b1, {req, " we"}, int'(ram_we), 1);
      if (ram_we) begin
         chk(ram_page == p, {req, " page"}, int'(ram_page), int'(p));
         chk(ram_col  == c, {req, " col"},  int'(ram_col),  int'(c));
         chk(ram_data == d, {req, " data"}, int'(ram_data), int'(d));
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      chk(ram_we == 1'b0, "R1 reset strobe", int'(ram_we), 0);
      chk(ram_page == 6'd0 && ram_col == 8'd0, "R1 reset outputs",
          int'(ram_page) + int'(ram_col), 0);

      for (int i = 0; i < NVEC; i++) begin
         logic [32:0] v;
         v = VEC[i];
         send(v[32], v[31:24], v[23]);
         if (v[22]) expect_write($sformatf("R6/R7/R8 vec %0d", i), v[21:16], v[15:8], v[7:0]);
         else chk(ram_we == 1'b0, $sformatf("R2/R9 vec %0d no write", i), int'(ram_we), 0);
      end

      // R6: strobe lasts one cycle only
      send(1'b1, 8'h90, 1'b0);
      expect_write("R6 single", 6'd0, 8'd2, 8'h90);
      @(negedge clk);
      chk(ram_we == 1'b0, "R6 strobe one cycle", int'(ram_we), 0);

      // R10: bytes without strobe are ignored, stream open
      @(negedge clk);
      rs = 1'b1; din = 8'h99; dir_page = 1'b0;
      repeat (2) begin
         @(negedge clk);
         chk(ram_we == 1'b0, "R10 no strobe", int'(ram_we), 0);
      end
      send(1'b1, 8'h9A, 1'b0);
      expect_write("R10 column unmoved", 6'd0, 8'd3, 8'h9A);

      // R1: reset mid-stream clears counters and closes the stream
      send(1'b0, 8'hB1, 1'b0);
      send(1'b1, 8'h05, 1'b0);
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      chk(ram_we == 1'b0, "R1 reset mid-run", int'(ram_we), 0);
      send(1'b1, 8'h5B, 1'b0);
      chk(ram_we == 1'b0, "R1 idle after reset", int'(ram_we), 0);
      send(1'b0, 8'h1D, 1'b0);
      send(1'b1, 8'h5A, 1'b0);
      expect_write("R1 counters cleared", 6'd0, 8'd0, 8'h5A);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule